// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where instruction fetch goes next in a 32-bit RISC core whose instructions are four bytes long and word aligned. It gets the address of the current instruction, the values of two source registers, the 16-bit branch displacement, the 26-bit jump field and a 4-bit operation select. From these it returns the next fetch address, a flag that says control flow left the sequential path, a write enable and data for the return-address register, and a flag for a register-sourced target that is not word aligned.

The unit is purely combinational. It sits between decode/register read and the program counter register, and it has no notion of delay slots, prediction or pipeline flushes. A branch offset counts words relative to the instruction after the branch. A direct jump does no addition: it keeps the top four bits of the current PC and replaces the rest with the target field and two zero bits.

Top module: `npc_unit`

## Requirements
- R1: Operation code 0 (sequential), and the unused codes 12 to 15, give next_pc = cur_pc + 4 (modulo 2^32), with redirect, link_we and fetch_misalign all low.
- R2: When a conditional branch (codes 1 to 8) is taken, next_pc = cur_pc + 4 + (sign-extended br_off × 4). When it is not taken, next_pc = cur_pc + 4 and redirect is low.
- R3: Code 1 (branch if equal) is taken when src_a and src_b match in all 32 bits. Code 2 (branch if not equal) is taken when they differ in any bit, bit 31 included.
- R4: The compare-to-zero branches read src_a as a signed two's-complement value: code 3 is taken when it is ≤ 0, code 4 when > 0, code 5 when < 0 and code 6 when ≥ 0. src_b is ignored.
- R5: Code 9 (direct jump) gives next_pc = {cur_pc[31:28], jmp_field, 2'b00} with redirect high.
- R6: Code 10 (jump and link) jumps like code 9 and also drives link_we high with link_val = cur_pc + 4, which goes to register 31.
- R7: Code 7 (branch if < 0 and link) and code 8 (branch if ≥ 0 and link) test src_a like codes 5 and 6. They drive link_we high with link_val = cur_pc + 4 only when the branch is taken.
- R8: Code 11 (jump register) gives next_pc = src_a in all 32 bits with redirect high. fetch_misalign is high exactly when code 11 is selected and src_a[1:0] is not 00.
- R9: link_we is low for every code other than 7, 8 and 10, and for codes 7 and 8 when they are not taken.
- R10: redirect is high for every taken branch and for codes 9, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Control-flow operation select |
| cur_pc | input | 32 | Address of the current instruction |
| src_a | input | 32 | First register source value |
| src_b | input | 32 | Second register source value |
| br_off | input | 16 | Signed word displacement of a branch |
| jmp_field | input | 26 | Target field of a direct jump |
| next_pc | output | 32 | Next fetch address |
| redirect | output | 1 | Control flow leaves the sequential path |
| link_we | output | 1 | Write enable for the return-address register |
| link_val | output | 32 | Return address (cur_pc + 4) |
| fetch_misalign | output | 1 | Register target is not word aligned |

## Verification
The bench targets register pairs that differ only in the sign bit. An equality test that ignores bit 31 would take code 1 there and skip code 2. It also uses the zero-compare boundaries 0, 0x7FFFFFFF, 0x80000000 and all-ones, where an unsigned or off-by-one test flips the taken result. A negative displacement at the top of the address space and a jump from a PC with high bits set catch a missing sign extension, and a target formed by addition instead of splicing the upper PC bits. Link-branches that are not taken, the unused op codes and a misaligned register target show up a stray link write, a spurious redirect or a misalignment flag that is missing.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    CF_SEQ    = 4'd0,
    CF_BEQ    = 4'd1,
    CF_BNE    = 4'd2,
    CF_BLEZ   = 4'd3,
    CF_BGTZ   = 4'd4,
    CF_BLTZ   = 4'd5,
    CF_BGEZ   = 4'd6,
    CF_BLTZL  = 4'd7,
    CF_BGEZL  = 4'd8,
    CF_JUMP   = 4'd9,
    CF_JLINK  = 4'd10,
    CF_JREG   = 4'd11
  } cf_op_e;

  localparam int unsigned OP_W = 4;

  function automatic logic is_cond_branch(input logic [OP_W-1:0] op);
    return (op >= CF_BEQ) && (op <= CF_BGEZL);
  endfunction

  function automatic logic is_link_op(input logic [OP_W-1:0] op);
    return (op == CF_BLTZL) || (op == CF_BGEZL) || (op == CF_JLINK);
  endfunction

  function automatic logic is_uncond_jump(input logic [OP_W-1:0] op);
    return (op == CF_JUMP) || (op == CF_JLINK) || (op == CF_JREG);
  endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            cond_met
);

  // Individual comparison results, named so that checks can refer to them.
  logic pair_eq;
  logic a_neg;
  logic a_zero;

  function automatic logic fn_all_zero(input logic [XLEN-1:0] v);
    return ~|v;
  endfunction

  assign pair_eq = (a == b);
  assign a_neg   = a[XLEN-1];
  assign a_zero  = fn_all_zero(a);

  always_comb begin
    unique case (op)
      CF_BEQ:             cond_met = pair_eq;
      CF_BNE:             cond_met = !pair_eq;
      CF_BLEZ:            cond_met = a_neg || a_zero;
      CF_BGTZ:            cond_met = !a_neg && !a_zero;
      CF_BLTZ, CF_BLTZL:  cond_met = a_neg;
      CF_BGEZ, CF_BGEZL:  cond_met = !a_neg;
      default:            cond_met = 1'b0;
    endcase
  end

  // R3: an equality branch is taken only for identical operands
  always_comb begin
    if (op == CF_BEQ && cond_met)
      a_r3_beq_equal: assert ($signed(a - b) == 0) else $error("R3 beq taken with unequal operands");
  end

  // R4: signed reading of the zero compares
  always_comb begin
    if (op == CF_BGTZ && cond_met)
      a_r4_bgtz_positive: assert ($signed(a) > 0) else $error("R4 bgtz taken on non-positive value");
    if (op == CF_BLEZ && !cond_met)
      a_r4_blez_positive: assert ($signed(a) > 0) else $error("R4 blez not taken on non-positive value");
  end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 16,
  parameter int unsigned JTW  = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [OFFW-1:0] off,
  input  logic [JTW-1:0]  jfield,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);

  localparam int unsigned ALIGN_B = 2;
  localparam int unsigned EXT_W   = XLEN - OFFW - ALIGN_B;
  localparam int unsigned HI_W    = XLEN - JTW - ALIGN_B;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  function automatic logic [XLEN-1:0] fn_word_disp(input logic [OFFW-1:0] d);
    return {{EXT_W{d[OFFW-1]}}, d, {ALIGN_B{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] fn_splice(input logic [XLEN-1:0] p,
                                                input logic [JTW-1:0]  f);
    return {p[XLEN-1 -: HI_W], f, {ALIGN_B{1'b0}}};
  endfunction

  assign seq_pc = pc + INSN_BYTES;
  assign br_pc  = seq_pc + fn_word_disp(off);
  assign jmp_pc = fn_splice(pc, jfield);

  // R5: a direct jump target keeps the upper PC bits and is word aligned
  always_comb begin
    a_r5_jump_upper: assert (jmp_pc[XLEN-1 -: HI_W] == pc[XLEN-1 -: HI_W])
      else $error("R5 jump target lost upper pc bits");
    a_r5_jump_aligned: assert (jmp_pc[ALIGN_B-1:0] == '0)
      else $error("R5 jump target not aligned");
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic            cond_met,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] jmp_pc,
  input  logic [XLEN-1:0] reg_pc,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic            link_we,
  output logic            misalign
);

  typedef enum logic [1:0] {SRC_SEQ, SRC_BR, SRC_JMP, SRC_REG} pc_src_e;

  pc_src_e src;
  logic    br_taken;

  assign br_taken = is_cond_branch(op) && cond_met;

  always_comb begin
    if (br_taken)                              src = SRC_BR;
    else if (op == CF_JUMP || op == CF_JLINK)  src = SRC_JMP;
    else if (op == CF_JREG)                    src = SRC_REG;
    else                                       src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_BR:  next_pc = br_pc;
      SRC_JMP: next_pc = jmp_pc;
      SRC_REG: next_pc = reg_pc;
      default: next_pc = seq_pc;
    endcase
  end

  assign redirect = (src != SRC_SEQ);
  assign link_we  = (op == CF_JLINK) || (br_taken && (op == CF_BLTZL || op == CF_BGEZL));
  assign misalign = (op == CF_JREG) && (reg_pc[1:0] != 2'b00);

  // R2: a taken branch must leave through the branch target
  always_comb begin
    if (is_cond_branch(op) && redirect)
      a_r2_branch_target: assert (next_pc == br_pc) else $error("R2 taken branch wrong target");
    if (is_cond_branch(op) && !cond_met)
      a_r2_not_taken_seq: assert (!redirect) else $error("R2 untaken branch redirected");
  end

  // R10: unconditional transfers always redirect
  always_comb begin
    if (is_uncond_jump(op))
      a_r10_jump_redirects: assert (redirect) else $error("R10 jump without redirect");
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 16,
  parameter int unsigned JTW  = 26
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [OFFW-1:0] br_off,
  input  logic [JTW-1:0]  jmp_field,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic            link_we,
  output logic [XLEN-1:0] link_val,
  output logic            fetch_misalign
);

  logic            cond_met;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jmp_pc;

  npc_cond_eval #(.XLEN(XLEN)) cond_i (
    .op       (op_sel),
    .a        (src_a),
    .b        (src_b),
    .cond_met (cond_met)
  );

  npc_target_gen #(.XLEN(XLEN), .OFFW(OFFW), .JTW(JTW)) tgt_i (
    .pc     (cur_pc),
    .off    (br_off),
    .jfield (jmp_field),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  npc_select #(.XLEN(XLEN)) sel_i (
    .op       (op_sel),
    .cond_met (cond_met),
    .seq_pc   (seq_pc),
    .br_pc    (br_pc),
    .jmp_pc   (jmp_pc),
    .reg_pc   (src_a),
    .next_pc  (next_pc),
    .redirect (redirect),
    .link_we  (link_we),
    .misalign (fetch_misalign)
  );

  assign link_val = seq_pc;

  // R1: no redirect means the sequential address
  always_comb begin
    if (!redirect)
      a_r1_fallthrough: assert (next_pc == seq_pc) else $error("R1 fall-through address wrong");
  end

  // R6: jump-and-link always writes the return address
  always_comb begin
    if (op_sel == CF_JLINK)
      a_r6_jal_links: assert (link_we && link_val == seq_pc) else $error("R6 jal missing link");
  end

  // R7: a link write only accompanies a taken transfer
  always_comb begin
    if (link_we)
      a_r7_link_taken: assert (redirect) else $error("R7 link without redirect");
  end

  // R8: misalignment flag only for register jumps
  always_comb begin
    if (fetch_misalign)
      a_r8_misalign_jr: assert (op_sel == CF_JREG && next_pc[1:0] != 2'b00)
        else $error("R8 misalign flag on wrong op");
  end

  // R9: link writes only from linking operations
  always_comb begin
    if (link_we)
      a_r9_link_ops_only: assert (is_link_op(op_sel)) else $error("R9 link from non-link op");
  end

endmodule

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;

  localparam real CLK_HALF = 4.0;  // 125 MHz
  localparam int  WD_CYCLES = 20000;

  localparam logic [3:0] K_SEQ = 4'd0, K_BEQ = 4'd1, K_BNE = 4'd2, K_BLEZ = 4'd3,
                         K_BGTZ = 4'd4, K_BLTZ = 4'd5, K_BGEZ = 4'd6, K_BLTZL = 4'd7,
                         K_BGEZL = 4'd8, K_J = 4'd9, K_JAL = 4'd10, K_JR = 4'd11;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] off;
    logic [25:0] tgt;
    logic        e_taken;
    logic        e_link;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{K_SEQ,   32'h0040_0000, 32'h0, 32'h0, 16'h0010, 26'h0, 1'b0, 1'b0},
    '{K_BEQ,   32'h0040_0100, 32'h1234_5678, 32'h1234_5678, 16'h0010, 26'h0, 1'b1, 1'b0},
    '{K_BEQ,   32'h0040_0100, 32'h8000_0001, 32'h0000_0001, 16'h0010, 26'h0, 1'b0, 1'b0},
    '{K_BNE,   32'h0040_0100, 32'h8000_0001, 32'h0000_0001, 16'h0020, 26'h0, 1'b1, 1'b0},
    '{K_BNE,   32'h0040_0100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0020, 26'h0, 1'b0, 1'b0},
    '{K_BLEZ,  32'h0040_0200, 32'h0, 32'h5, 16'hFFF0, 26'h0, 1'b1, 1'b0},
    '{K_BLEZ,  32'h0040_0200, 32'h1, 32'h0, 16'hFFF0, 26'h0, 1'b0, 1'b0},
    '{K_BGTZ,  32'h0040_0200, 32'h8000_0000, 32'h0, 16'h0004, 26'h0, 1'b0, 1'b0},
    '{K_BGTZ,  32'h0040_0200, 32'h7FFF_FFFF, 32'h0, 16'h0004, 26'h0, 1'b1, 1'b0},
    '{K_BLTZ,  32'h0040_0300, 32'hFFFF_FFFF, 32'h0, 16'hFFFE, 26'h0, 1'b1, 1'b0},
    '{K_BLTZ,  32'h0040_0300, 32'h0, 32'hFFFF_FFFF, 16'hFFFE, 26'h0, 1'b0, 1'b0},
    '{K_BGEZ,  32'h0040_0300, 32'h0, 32'h0, 16'h7FFF, 26'h0, 1'b1, 1'b0},
    '{K_BGEZ,  32'h0040_0300, 32'h8000_0000, 32'h0, 16'h7FFF, 26'h0, 1'b0, 1'b0},
    '{K_BLTZL, 32'h0040_0400, 32'hFFFF_FFFB, 32'h0, 16'h0008, 26'h0, 1'b1, 1'b1},
    '{K_BLTZL, 32'h0040_0400, 32'h0000_0003, 32'h0, 16'h0008, 26'h0, 1'b0, 1'b0},
    '{K_BGEZL, 32'h0040_0400, 32'h0, 32'h0, 16'h8000, 26'h0, 1'b1, 1'b1},
    '{K_BGEZL, 32'h0040_0400, 32'hFFFF_FFF0, 32'h0, 16'h8000, 26'h0, 1'b0, 1'b0},
    '{K_J,     32'hA000_1000, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 1'b1, 1'b0},
    '{K_JAL,   32'h5000_2000, 32'h0, 32'h0, 16'h0, 26'h012_3456, 1'b1, 1'b1},
    '{K_JR,    32'h0040_0500, 32'h0040_0020, 32'h0, 16'h0, 26'h0, 1'b1, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [31:0] cur_pc, src_a, src_b;
  logic [15:0] br_off;
  logic [25:0] jmp_field;
  logic [31:0] next_pc, link_val;
  logic        redirect, link_we, fetch_misalign;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  npc_unit dut_i (
    .op_sel(op_sel), .cur_pc(cur_pc), .src_a(src_a), .src_b(src_b),
    .br_off(br_off), .jmp_field(jmp_field), .next_pc(next_pc),
    .redirect(redirect), .link_we(link_we), .link_val(link_val),
    .fetch_misalign(fetch_misalign)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  // Independent model of the next address.
  function automatic logic [31:0] model_npc(input logic [3:0] op, input logic [31:0] pc,
                                            input logic [31:0] a, input logic [15:0] off,
                                            input logic [25:0] t, input logic taken);
    int signed disp;
    disp = $signed(off) * 4;
    if (op == K_J || op == K_JAL) return (pc & 32'hF000_0000) | ({6'b0, t} << 2);
    if (op == K_JR) return a;
    if (taken) return pc + 32'd4 + 32'(disp);
    return pc + 32'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] pc, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] off, input logic [25:0] t);
    @(negedge clk);
    op_sel = op; cur_pc = pc; src_a = a; src_b = b; br_off = off; jmp_field = t;
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    op_sel = K_SEQ; cur_pc = 32'h0; src_a = '0; src_b = '0; br_off = '0; jmp_field = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 idle state: sequential from address 0
    chk("R1 reset next_pc", next_pc, 32'h4);
    chk("R1 reset flags", {29'b0, redirect, link_we, fetch_misalign}, 32'h0);
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.op, v.pc, v.a, v.b, v.off, v.tgt);
      chk($sformatf("R2/R5/R8 next_pc vec%0d", i), next_pc,
          model_npc(v.op, v.pc, v.a, v.off, v.tgt, v.e_taken));
      chk($sformatf("R3/R4/R10 redirect vec%0d", i), {31'b0, redirect}, {31'b0, v.e_taken});
      chk($sformatf("R7/R9 link_we vec%0d", i), {31'b0, link_we}, {31'b0, v.e_link});
      if (v.e_link) chk($sformatf("R6 link_val vec%0d", i), link_val, v.pc + 32'd4);
      chk($sformatf("R8 no misalign vec%0d", i), {31'b0, fetch_misalign}, 32'h0);
    end

    // R1: unused codes behave as sequential, including wraparound
    for (int c = 12; c < 16; c++) begin
      drive(4'(c), 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h0, 16'h0100, 26'h1);
      chk("R1 undef next_pc", next_pc, 32'h0);
      chk("R1 undef flags", {29'b0, redirect, link_we, fetch_misalign}, 32'h0);
    end

    // R2: negative displacement from near zero wraps
    drive(K_BEQ, 32'h0000_0000, 32'h7, 32'h7, 16'hFFFE, 26'h0);
    chk("R2 negative wrap", next_pc, 32'hFFFF_FFFC);

    // R4: src_b ignored by zero compares
    drive(K_BGTZ, 32'h1000_0000, 32'h0, 32'h0000_0009, 16'h0001, 26'h0);
    chk("R4 src_b ignored", {31'b0, redirect}, 32'h0);
    chk("R4 src_b ignored pc", next_pc, 32'h1000_0004);

    // R8: misaligned register target, full value kept
    drive(K_JR, 32'h0040_0000, 32'h8000_0003, 32'h0, 16'h0, 26'h0);
    chk("R8 jr full target", next_pc, 32'h8000_0003);
    chk("R8 misalign high", {31'b0, fetch_misalign}, 32'h1);
    drive(K_JR, 32'h0040_0000, 32'h0000_0002, 32'h0, 16'h0, 26'h0);
    chk("R8 misalign bit1", {31'b0, fetch_misalign}, 32'h1);

    // R9: non-link jump register does not link
    chk("R9 jr no link", {31'b0, link_we}, 32'h0);

    // R5: jump from PC whose upper bits are all ones
    drive(K_J, 32'hF000_0000, 32'h0, 32'h0, 16'h0, 26'h0);
    chk("R5 splice upper", next_pc, 32'hF000_0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule